// File: doc/BRIEF.md
# Secondary Processor Run, Bus and Interrupt Control Register

This block is the control word through which a host processor manages a secondary processor. It is 16 bits wide and writable by byte. The low byte carries a run bit and a bus-request bit. A write to the low byte turns these bits into actions:

- a one-cycle reset pulse when the run bit goes from 0 to 1;
- a halt level that follows the bus-request bit while the processor runs;
- a forced halt while it is held stopped.

The high byte carries an interrupt-request bit. Writing a 1 to it raises a level-2 interrupt toward the secondary processor, but only when the secondary side has unmasked that line. A 3-bit priority level is derived from the pending interrupts and the secondary side's mask byte. The secondary side clears the pending interrupt with an acknowledge input.

The stored low byte is visible on an output so that the host-facing read path can return it.

Top module: `subcpu_ctrl_reg`

## Requirements
- R1: After reset the stored control byte is 0x00, the halt output is 1, and the reset pulse, the pending flag and the interrupt level are all 0.
- R2: A low-byte write with bit 0 = 1 while the stored bit 0 is 0 produces a reset pulse exactly one cycle long, in the cycle after the write.
- R3: A low-byte write never pulses reset when the stored bit 0 is already 1, or when bit 0 is written as 0.
- R4: After a low-byte write, halt equals written bit 1 if written bit 0 is 1. Halt is 1 if written bit 0 is 0, whatever bit 1 is.
- R5: The written low byte is stored unchanged in all eight bits and shown on `ctrl_byte` in the cycle after the write.
- R6: A high-byte write with data bit 8 = 1 while `irq_mask` bit 2 is 1 sets the pending flag in the next cycle.
- R7: A high-byte write with bit 8 = 1 while `irq_mask` bit 2 is 0 leaves the pending flag unchanged. So does a high-byte write with bit 8 = 0.
- R8: The pending flag stands for bit 2 of an 8-bit pending vector. `irq_level` equals bits 3..1 of (pending vector AND `irq_mask`). It follows the live mask without delay, giving 3'b010 when pending and mask bit 2 are both 1, and 0 otherwise.
- R9: `irq_ack` clears the pending flag in the next cycle. An accepted request in the same cycle wins over the acknowledge.
- R10: Byte enables select the halves: `wr_be[0]` for the control byte and `wr_be[1]` for the request. A low-only write never touches the pending flag, a high-only write leaves the control byte and halt alone, and a word write does both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| wr_data | input | 16 | Host write data |
| irq_mask | input | 8 | Interrupt mask byte from the secondary side |
| irq_ack | input | 1 | Secondary side clears the pending interrupt |
| ctrl_byte | output | 8 | Stored control byte |
| sub_rst_pulse | output | 1 | One-cycle reset pulse to the secondary processor |
| sub_halt | output | 1 | Halt / bus-grant request level |
| irq_pending | output | 1 | Level-2 interrupt pending flag |
| irq_level | output | 3 | Interrupt priority level to the secondary processor |

## Verification
The following results are registered and appear one clock edge after the write or acknowledge that causes them: the reset pulse, halt, the stored byte and the pending flag. The interrupt level is combinational on the registered flag and the live mask, so it changes with the flag and, within the same cycle, with any mask change. Each bench task drives its inputs on a falling edge, lets one rising edge pass, and samples on the next falling edge. A second sample one cycle later confirms that the reset pulse has dropped again.

// File: rtl/subctl_pkg.sv
package subctl_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int BE_W     = WORD_W / BYTE_W;
  localparam int RUN_BIT  = 0;
  localparam int BREQ_BIT = 1;
  localparam int REQ_BIT  = 0;
  localparam int IRQ_LINE = 2;
  localparam int LVL_W    = 3;

  // halt level implied by a written control byte
  function automatic logic halt_for(input logic [BYTE_W-1:0] b);
    return b[RUN_BIT] ? b[BREQ_BIT] : 1'b1;
  endfunction

  // priority level from pending vector and mask
  function automatic logic [LVL_W-1:0] level_for(input logic [BYTE_W-1:0] pend,
                                                 input logic [BYTE_W-1:0] mask);
    logic [BYTE_W-1:0] m;
    m = (pend & mask) >> 1;
    return m[LVL_W-1:0];
  endfunction
endpackage

// File: rtl/subctl_run_unit.sv
module subctl_run_unit
  import subctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] lo_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              halt_q,
  output logic              pulse_q,
  output logic              run_rise
);
  assign run_rise = lo_wr && lo_data[RUN_BIT] && !ctrl_q[RUN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      halt_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= run_rise;
      if (lo_wr) begin
        ctrl_q <= lo_data;
        halt_q <= halt_for(lo_data);
      end
    end
  end
endmodule

// File: rtl/subctl_irq_unit.sv
module subctl_irq_unit
  import subctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [BYTE_W-1:0] mask,
  input  logic              ack,
  output logic              pend_q,
  output logic [LVL_W-1:0]  level,
  output logic              accept
);
  logic [BYTE_W-1:0] pend_vec;

  assign accept = req_wr && mask[IRQ_LINE];

  always_comb begin
    pend_vec           = '0;
    pend_vec[IRQ_LINE] = pend_q;
  end

  assign level = level_for(pend_vec, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (accept)  pend_q <= 1'b1;
    else if (ack)     pend_q <= 1'b0;
  end
endmodule

// File: rtl/subcpu_ctrl_reg.sv
module subcpu_ctrl_reg
  import subctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] irq_mask,
  input  logic              irq_ack,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic              sub_rst_pulse,
  output logic              sub_halt,
  output logic              irq_pending,
  output logic [LVL_W-1:0]  irq_level
);
  logic [BYTE_W-1:0] lane [BE_W];
  logic [BE_W-1:0]   lane_wr;
  logic              run_rise;
  logic              req_accept;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lane[i]    = wr_data[i*BYTE_W +: BYTE_W];
    assign lane_wr[i] = wr_en && wr_be[i];
  end

  subctl_run_unit u_run (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(lane_wr[0]), .lo_data(lane[0]),
    .ctrl_q(ctrl_byte), .halt_q(sub_halt), .pulse_q(sub_rst_pulse),
    .run_rise(run_rise)
  );

  subctl_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n),
    .req_wr(lane_wr[1] && lane[1][REQ_BIT]),
    .mask(irq_mask), .ack(irq_ack),
    .pend_q(irq_pending), .level(irq_level),
    .accept(req_accept)
  );
endmodule

// File: rtl/subcpu_ctrl_reg_chk.sv
module subcpu_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic [7:0]  irq_mask,
  input logic        irq_ack,
  input logic [7:0]  ctrl_byte,
  input logic        sub_rst_pulse,
  input logic        sub_halt,
  input logic        irq_pending,
  input logic [2:0]  irq_level,
  input logic        run_rise,
  input logic        req_accept
);
  a_r2_pulse_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[0] && wr_data[0] && !ctrl_byte[0]) |=> sub_rst_pulse);
  a_r3_pulse_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst_pulse |-> $rose(ctrl_byte[0]));
  a_r4_stopped_halts: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_byte[0] |-> sub_halt);
  a_r4_running_follows_breq: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte[0] |-> (sub_halt == ctrl_byte[1]));
  a_r7_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && !irq_mask[2] && !irq_pending) |=> !irq_pending);
  a_r8_level_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> irq_pending);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !req_accept) |=> !irq_pending);
  a_r10_high_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[0]) |=> ($stable(ctrl_byte) && $stable(sub_halt) && !sub_rst_pulse));
  a_r10_accept_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (wr_en && wr_be[1]));
  a_r2_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |-> (wr_en && wr_be[0]));
endmodule

bind subcpu_ctrl_reg subcpu_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .irq_mask(irq_mask), .irq_ack(irq_ack), .ctrl_byte(ctrl_byte),
  .sub_rst_pulse(sub_rst_pulse), .sub_halt(sub_halt), .irq_pending(irq_pending),
  .irq_level(irq_level), .run_rise(run_rise), .req_accept(req_accept)
);

// File: tb/subcpu_ctrl_reg_bench.sv
`timescale 1ns/1ps
module subcpu_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  irq_mask = '0;
  logic        irq_ack = 1'b0;
  logic [7:0]  ctrl_byte;
  logic        sub_rst_pulse, sub_halt, irq_pending;
  logic [2:0]  irq_level;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  subcpu_ctrl_reg u_subcpu_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .irq_mask(irq_mask), .irq_ack(irq_ack), .ctrl_byte(ctrl_byte),
    .sub_rst_pulse(sub_rst_pulse), .sub_halt(sub_halt),
    .irq_pending(irq_pending), .irq_level(irq_level)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, one rising edge, back on a falling edge
  task automatic write(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic ack_cycle();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl", {8'h0, ctrl_byte}, 16'h0);
    check("R1 halt", {15'h0, sub_halt}, 16'h1);
    check("R1 pulse", {15'h0, sub_rst_pulse}, 16'h0);
    check("R1 pending", {15'h0, irq_pending}, 16'h0);
    check("R1 level", {13'h0, irq_level}, 16'h0);
  endtask

  task automatic t_run_edges();
    write(2'b01, 16'h0001);
    check("R2 pulse", {15'h0, sub_rst_pulse}, 16'h1);
    check("R4 run release", {15'h0, sub_halt}, 16'h0);
    @(negedge clk);
    check("R2 one cycle", {15'h0, sub_rst_pulse}, 16'h0);
    write(2'b01, 16'h0003);
    check("R3 already running", {15'h0, sub_rst_pulse}, 16'h0);
    check("R4 breq halts", {15'h0, sub_halt}, 16'h1);
    write(2'b01, 16'h0000);
    check("R3 write zero", {15'h0, sub_rst_pulse}, 16'h0);
    check("R4 stopped halts", {15'h0, sub_halt}, 16'h1);
    write(2'b01, 16'h0002);
    check("R4 stopped breq", {15'h0, sub_halt}, 16'h1);
    write(2'b01, 16'h0001);
    check("R2 second rise", {15'h0, sub_rst_pulse}, 16'h1);
  endtask

  task automatic t_store();
    write(2'b01, 16'h00A5);
    check("R5 stored", {8'h0, ctrl_byte}, 16'h00A5);
    check("R3 no pulse A5", {15'h0, sub_rst_pulse}, 16'h0);
    check("R4 A5 halt", {15'h0, sub_halt}, 16'h0);
    write(2'b01, 16'h005A);
    check("R5 stored 5A", {8'h0, ctrl_byte}, 16'h005A);
  endtask

  task automatic t_irq();
    irq_mask = 8'h00;
    write(2'b10, 16'h0100);
    check("R7 masked", {15'h0, irq_pending}, 16'h0);
    irq_mask = 8'h04;
    write(2'b10, 16'h0000);
    check("R7 write zero", {15'h0, irq_pending}, 16'h0);
    write(2'b10, 16'h0100);
    check("R6 accepted", {15'h0, irq_pending}, 16'h1);
    check("R8 level", {13'h0, irq_level}, 16'h2);
    check("R10 ctrl kept", {8'h0, ctrl_byte}, 16'h005A);
    irq_mask = 8'hFB;
    #1;
    check("R8 live mask off", {13'h0, irq_level}, 16'h0);
    check("R7 mask off keeps", {15'h0, irq_pending}, 16'h1);
    irq_mask = 8'hFF;
    #1;
    check("R8 full mask", {13'h0, irq_level}, 16'h2);
    ack_cycle();
    check("R9 ack", {15'h0, irq_pending}, 16'h0);
    check("R8 level after ack", {13'h0, irq_level}, 16'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h0100; irq_ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; irq_ack = 1'b0;
    check("R9 set wins", {15'h0, irq_pending}, 16'h1);
    ack_cycle();
  endtask

  task automatic t_lanes();
    irq_mask = 8'h04;
    write(2'b01, 16'h0100);
    check("R10 low keeps pending", {15'h0, irq_pending}, 16'h0);
    check("R10 low stored", {8'h0, ctrl_byte}, 16'h0000);
    write(2'b11, 16'h0103);
    check("R10 word ctrl", {8'h0, ctrl_byte}, 16'h0003);
    check("R10 word pending", {15'h0, irq_pending}, 16'h1);
    check("R2 word pulse", {15'h0, sub_rst_pulse}, 16'h1);
    check("R4 word halt", {15'h0, sub_halt}, 16'h1);
    write(2'b10, 16'h0100);
    check("R10 high keeps halt", {15'h0, sub_halt}, 16'h1);
    check("R10 high keeps ctrl", {8'h0, ctrl_byte}, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_edges();
    t_store();
    t_irq();
    t_lanes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule